// File: doc/BRIEF.md
# Bus-Mapped Successive-Approximation Converter Sequencer

This block runs an 8-bit successive-approximation conversion for an analog front end that lives outside it: a resistor-ladder DAC, a comparator and a track/hold switch. It sits on a byte-wide external data bus at one fixed address. A processor starts a conversion by writing any byte to that address. The block then opens the track/hold switch to freeze the input. It walks the DAC code from the most significant bit down to the least, keeping each trial bit when the comparator reports the held input at or above the DAC output.

When the last bit is settled, the code is copied into a separate result register and the hold switch returns to tracking. One cycle later the DAC code goes back to zero and the block is idle again. An active-low interrupt goes low when the result is stored. It stays low until the processor reads the same address, and that read returns the result and releases the interrupt. A full conversion takes 18 clock cycles from the start write, well inside a 50-cycle budget.

Top module: `sar_bus_adc`

## Requirements
- R1: After reset, `dac_code` is 0, `track_en` is 1, `busy` is 0, `irq_n` is 1, `bus_rdata` is 0, and the stored result is 0.
- R2: A write (`bus_wr`=1) with `bus_addr` equal to `BASE_ADDR` while idle starts a conversion. In the cycle after that write edge, `busy` is 1. The data byte has no effect on the result. A write to any other address starts nothing.
- R3: `track_en` falls at the start edge and stays 0 until the result is stored. The result therefore reflects the input as it was at the start write, even if the input later changes.
- R4: Trials run MSB first with one bit under test. Each trial takes two cycles, set then decide. In the cycle after the start edge, `dac_code` is 8'h80.
- R5: `cmp_in`=1 means the held input is at or above the DAC output, and the bit under test is kept. Otherwise the bit is cleared. With an ideal comparator and an input in quarter-LSB steps 0..1023, the result is floor(input/4): code 0 at the bottom and 255 at full scale.
- R6: 17 edges after the start edge, `dac_code` still shows the final code and `track_en` is 1. One edge later, `dac_code` is 0 and `busy` is 0.
- R7: `irq_n` goes low on the edge that stores the result. It stays low until a read (`bus_rd`=1) at `BASE_ADDR`. After that read edge, `bus_rdata` holds the result and `irq_n` is 1.
- R8: A start write that arrives while `busy` is 1 is ignored. The running conversion keeps its timing and result, and no second conversion follows.
- R9: From the start edge until `busy` falls, a conversion takes no more than 50 cycles (18 in this design).
- R10: A read at any other address returns 0 on `bus_rdata` and leaves `irq_n` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (16) | External data bus address |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_wdata | input | 8 | Write data (ignored) |
| bus_rdata | output | 8 | Registered read data: the result for a mapped read, else 0 |
| cmp_in | input | 1 | Comparator: 1 when held input >= DAC output |
| dac_code | output | RES_W (8) | Code driven to the ladder DAC |
| track_en | output | 1 | 1 = hold switch tracks input, 0 = holding |
| busy | output | 1 | Conversion in progress |
| irq_n | output | 1 | Active-low completion interrupt, level |

## Verification
A wrong trial mask or a wrong decide polarity shows on `dac_code` within two cycles of the start. The first visible trial value is fixed at 8'h80, and every later trial depends on the comparator answer before it. A sequencer stuck in the wrong state shows up as `busy` or `track_en` off its 18-cycle schedule, or as a nonzero DAC code while idle. An interrupt or result register that goes wrong only shows on the next mapped read. For that reason the bench reads after every conversion, and also probes a neighbouring address before reading.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SET    = 3'd1,
    ST_DECIDE = 3'd2,
    ST_LATCH  = 3'd3,
    ST_CLEAR  = 3'd4
  } sar_state_t;
endpackage

// File: rtl/sar_bus_decode.sv
module sar_bus_decode #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic              wr_hit,
  output logic              rd_hit
);
  logic sel;

  always_comb begin
    sel    = (bus_addr == BASE_ADDR);
    wr_hit = sel && bus_wr;
    rd_hit = sel && bus_rd;
  end
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_adc_pkg::*;
#(
  parameter int RES_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_req,
  input  logic             cmp_in,
  output logic [RES_W-1:0] dac_code,
  output logic             track_en,
  output logic             busy,
  output logic             latch_en
);
  localparam logic [RES_W-1:0] MSB_MASK = {1'b1, {(RES_W-1){1'b0}}};

  sar_state_t       state;
  logic [RES_W-1:0] trial_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      trial_mask <= '0;
      dac_code   <= '0;
      track_en   <= 1'b1;
      busy       <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_req) begin
            track_en   <= 1'b0;
            busy       <= 1'b1;
            trial_mask <= MSB_MASK;
            state      <= ST_SET;
          end
        end
        ST_SET: begin
          dac_code <= dac_code | trial_mask;
          state    <= ST_DECIDE;
        end
        ST_DECIDE: begin
          if (!cmp_in) begin
            dac_code <= dac_code & ~trial_mask;
          end
          if (trial_mask[0]) begin
            state <= ST_LATCH;
          end else begin
            trial_mask <= trial_mask >> 1;
            state      <= ST_SET;
          end
        end
        ST_LATCH: begin
          track_en <= 1'b1;
          state    <= ST_CLEAR;
        end
        ST_CLEAR: begin
          dac_code <= '0;
          busy     <= 1'b0;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign latch_en = (state == ST_LATCH);
endmodule

// File: rtl/sar_result.sv
module sar_result #(
  parameter int RES_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             latch_en,
  input  logic [RES_W-1:0] code_in,
  input  logic             rd_hit,
  output logic [RES_W-1:0] rdata,
  output logic             irq_n
);
  logic [RES_W-1:0] result_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      rdata    <= '0;
      irq_n    <= 1'b1;
    end else begin
      if (latch_en) begin
        result_q <= code_in;
      end
      rdata <= rd_hit ? result_q : '0;
      if (latch_en) begin
        irq_n <= 1'b0;
      end else if (rd_hit) begin
        irq_n <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sar_bus_adc.sv
module sar_bus_adc #(
  parameter int ADDR_W = 16,
  parameter int RES_W  = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hC000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [RES_W-1:0]  bus_rdata,
  input  logic              cmp_in,
  output logic [RES_W-1:0]  dac_code,
  output logic              track_en,
  output logic              busy,
  output logic              irq_n
);
  logic wr_hit;
  logic rd_hit;
  logic latch_en;
  logic wdata_unused;

  // Start writes carry no meaning in their data byte.
  assign wdata_unused = ^bus_wdata;

  sar_bus_decode #(
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR)
  ) u_dec (
    .bus_addr(bus_addr),
    .bus_wr  (bus_wr),
    .bus_rd  (bus_rd),
    .wr_hit  (wr_hit),
    .rd_hit  (rd_hit)
  );

  sar_seq #(
    .RES_W(RES_W)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start_req(wr_hit),
    .cmp_in   (cmp_in),
    .dac_code (dac_code),
    .track_en (track_en),
    .busy     (busy),
    .latch_en (latch_en)
  );

  sar_result #(
    .RES_W(RES_W)
  ) u_res (
    .clk     (clk),
    .rst     (rst),
    .latch_en(latch_en),
    .code_in (dac_code),
    .rd_hit  (rd_hit),
    .rdata   (bus_rdata),
    .irq_n   (irq_n)
  );
endmodule

// File: rtl/sar_bus_adc_chk.sv
module sar_bus_adc_chk #(
  parameter int ADDR_W = 16,
  parameter int RES_W  = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hC000,
  parameter int MAX_CONV_CYCLES = 50
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [RES_W-1:0]  dac_code,
  input logic              track_en,
  input logic              busy,
  input logic              irq_n
);
  logic [7:0] run_cnt;
  logic       map_wr;
  logic       map_rd;

  assign map_wr = bus_wr && (bus_addr == BASE_ADDR);
  assign map_rd = bus_rd && (bus_addr == BASE_ADDR);

  always_ff @(posedge clk) begin
    if (rst || !busy) run_cnt <= '0;
    else if (run_cnt != 8'hFF) run_cnt <= run_cnt + 8'd1;
  end

  // R2: an idle mapped write starts a conversion and opens the hold switch
  a_r2_start: assert property (@(posedge clk) disable iff (rst)
    (map_wr && !busy) |=> (busy && !track_en));

  // R3: holding only begins at a start
  a_r3_hold_on_start: assert property (@(posedge clk) disable iff (rst)
    $fell(track_en) |-> $rose(busy));

  // R6: the DAC sits at zero whenever idle
  a_r6_dac_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (dac_code == '0));

  // R7: interrupt only falls at the end of a conversion
  a_r7_irq_source: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_n) |-> (busy && track_en));

  // R7: pending interrupt stays until a mapped read
  a_r7_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    (!irq_n && !map_rd) |=> !irq_n);

  // R9: conversion length bounded
  a_r9_conv_bound: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run_cnt < MAX_CONV_CYCLES));
endmodule

bind sar_bus_adc sar_bus_adc_chk #(
  .ADDR_W   (ADDR_W),
  .RES_W    (RES_W),
  .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .bus_addr(bus_addr),
  .bus_wr  (bus_wr),
  .bus_rd  (bus_rd),
  .dac_code(dac_code),
  .track_en(track_en),
  .busy    (busy),
  .irq_n   (irq_n)
);

// File: tb/sar_bus_adc_tb.sv
module sar_bus_adc_tb;
  localparam logic [15:0] BASE  = 16'hC000;
  localparam logic [15:0] OTHER = 16'hC001;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        cmp_in;
  logic [7:0]  dac_code;
  logic        track_en;
  logic        busy;
  logic        irq_n;

  logic [9:0]  vin = '0;
  logic [9:0]  held = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sar_bus_adc u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmp_in(cmp_in), .dac_code(dac_code), .track_en(track_en),
    .busy(busy), .irq_n(irq_n)
  );

  // Ideal track/hold and comparator; input in quarter-LSB units
  always @(posedge clk) if (track_en) held <= vin;
  assign cmp_in = (held >= {dac_code, 2'b00});

  function automatic logic [7:0] expect_code(input logic [9:0] v);
    return v[9:2];
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic convert(input logic [9:0] v, input logic [7:0] d, input bit extra_start);
    logic [7:0] exp;
    exp = expect_code(v);
    vin = v;
    bus_write(BASE, d);
    chk("R2 busy after start", {7'd0, busy}, 8'd1);
    chk("R3 holding after start", {7'd0, track_en}, 8'd0);
    for (int i = 1; i <= 18; i++) begin
      if (i == 2 && extra_start) begin
        bus_addr = BASE; bus_wdata = 8'h5A; bus_wr = 1'b1;
      end
      if (i == 3) vin = 10'($urandom_range(0, 1023));
      @(negedge clk);
      bus_wr = 1'b0;
      if (i == 1) chk("R4 first trial MSB", dac_code, 8'h80);
      if (i == 16) chk("R3 still holding", {7'd0, track_en}, 8'd0);
      if (i == 17) begin
        chk("R5 final code", dac_code, exp);
        chk("R6 track restored", {7'd0, track_en}, 8'd1);
        chk("R7 irq asserted", {7'd0, irq_n}, 8'd0);
      end
      if (i == 18) begin
        chk("R6 dac cleared", dac_code, 8'd0);
        chk("R9 busy done in 18", {7'd0, busy}, 8'd0);
      end
    end
    @(negedge clk);
    if (extra_start) chk("R8 no second conversion", {7'd0, busy}, 8'd0);
    bus_read(OTHER);
    chk("R10 other read zero", bus_rdata, 8'd0);
    chk("R10 irq kept", {7'd0, irq_n}, 8'd0);
    bus_read(BASE);
    chk("R7 read result", bus_rdata, exp);
    chk("R7 irq released", {7'd0, irq_n}, 8'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 dac", dac_code, 8'd0);
    chk("R1 track", {7'd0, track_en}, 8'd1);
    chk("R1 busy", {7'd0, busy}, 8'd0);
    chk("R1 irq", {7'd0, irq_n}, 8'd1);
    bus_read(BASE);
    chk("R1 result zero", bus_rdata, 8'd0);

    bus_write(OTHER, 8'hFF);
    @(negedge clk);
    chk("R2 other addr no start", {7'd0, busy}, 8'd0);

    convert(10'd0, 8'h00, 1'b0);     // R5 bottom
    convert(10'd1023, 8'hFF, 1'b0);  // R5 full scale
    convert(10'd512, 8'h12, 1'b0);   // R5 equality keeps bit
    convert(10'd511, 8'h34, 1'b0);
    convert(10'd300, 8'hAA, 1'b1);   // R8 start while busy
    convert(10'd300, 8'h55, 1'b0);   // R2 data ignored
    for (int k = 0; k < 20; k++) begin
      convert(10'($urandom_range(0, 1023)), 8'($urandom), bit'(k % 3 == 0));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule